// File: doc/BRIEF.md
# Buffered SPI Master with Byte-Sized FIFOs

This block is a memory-mapped SPI master. Software uses a small register port to set the word size, the clock mode and the bit rate. It pushes outgoing words into a transmit FIFO and pops incoming words from a receive FIFO. The shift engine takes words from the transmit FIFO and shifts them out MSB first. Each word it sends produces one word in the receive FIFO. Words go out back to back for as long as the transmit FIFO has data.

Both FIFOs are measured in bytes rather than words. The number of words they hold therefore depends on the word size. A status register reports both fill levels and a sticky receive-overflow flag, and that flag is cleared by a separate write-1-to-clear strobe. The block can also drive slave-select on its own. In that case slave-select stays low while words are moving and goes high once the transmit FIFO and the shifter are both empty.

Top module: `spi_byte_fifo_master`

## Requirements
- R1: Register index `addr_i` selects control (0), status (1), data (2) or divider (3). Control reads back only its implemented bits: 5, 6, 8, 9, 11:10, 15, 16 and 28, mask 0x10018F60. The divider reads back its low 9 bits. After reset, every register reads 0, `ss_no` is 1 and `sclk_o` is 0.
- R2: The word-size field is control bits 11:10. Code 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits, and the reserved code 3 behaves as 8 bits. A data write pushes only the low word-size bits of `wdata_i`.
- R3: Each FIFO holds 16 bytes when control bit 16 is set: 16, 8 or 4 words. It holds 1 word when bit 16 is clear. A push to a full transmit FIFO is dropped.
- R4: Reading the data register pops the receive FIFO. A pop from an empty receive FIFO changes nothing.
- R5: With N equal to divider bits 8:0, every SCLK half period lasts N+1 clocks. One word of W bits therefore occupies 2·W·(N+1) clocks.
- R6: Words are shifted out MSB first. With `miso_i` tied to `mosi_o`, every word sent comes back unchanged. Queued words follow one another with no idle gap.
- R7: Control bit 6 set makes SCLK idle high. When bit 8 is set, the first SCLK transition of a word comes in the middle of its first bit. When bit 8 is clear, that transition comes right at the start of the word.
- R8: With control bit 9 clear, received bits are sampled at the middle of each bit time. With bit 9 set, they are sampled at the end of the bit time.
- R9: Status bits 20:16 hold the transmit FIFO word count and status bits 28:24 hold the receive FIFO word count.
- R10: Status bit 6 sets when a received word finds the receive FIFO full, and that word is dropped. The bit stays set until a `clr_i` access to index 1 with `wdata_i` bit 6 high.
- R11: With control bit 28 set, `ss_no` goes low when the first word is loaded and stays low until the transmit FIFO and the shifter are both empty. With bit 28 clear, `ss_no` stays high.
- R12: Shifting starts only while control bit 15 (on) and bit 5 (master) are both set. Clearing bit 15 empties both FIFOs, stops the shifter, returns SCLK to its idle level and raises `ss_no`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (pops receive FIFO at index 2) |
| clr_i | input | 1 | Write-1-to-clear strobe for the status register |
| addr_i | input | 2 | Register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | 1 | Automatic slave-select, active low |

## Verification
A broken FIFO pointer or level shows up on the next status read as a wrong word count, and at the data register as a wrong or repeated word. A divider or bit counter that is off by one stretches or shortens the `ss_no` low window. That error is visible within the word that goes wrong, because the window length is an exact multiple of N+1. A wrong phase or sample-point choice shows in the very first bit: SCLK has the wrong level in the first cycle of the word, or the received word reads all-zeros instead of all-ones against a clock-derived serial input.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;
  typedef enum logic [1:0] {WS_8 = 2'd0, WS_16 = 2'd1, WS_32 = 2'd2, WS_RSV = 2'd3} wsize_e;

  localparam int MAX_W = 32;
  // control bit positions
  localparam int C_MST  = 5;
  localparam int C_CPOL = 6;
  localparam int C_CKE  = 8;
  localparam int C_SMP  = 9;
  localparam int C_WS   = 10;
  localparam int C_ON   = 15;
  localparam int C_ENH  = 16;
  localparam int C_ASS  = 28;
  // status bit positions
  localparam int S_ROV  = 6;
  localparam int S_TXL  = 16;
  localparam int S_RXL  = 24;

  function automatic logic [1:0] size_shift(input logic [1:0] code);
    case (code)
      WS_16:   return 2'd1;
      WS_32:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [5:0] size_bits(input logic [1:0] code);
    return 6'd8 << size_shift(code);
  endfunction

  function automatic logic [MAX_W-1:0] size_mask(input logic [1:0] code);
    case (size_shift(code))
      2'd1:    return 32'h0000_FFFF;
      2'd2:    return 32'hFFFF_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction
endpackage

// File: rtl/spi_mst_fifo.sv
module spi_mst_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [LW-1:0] cap_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q >= cap_i);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rp_q];
  assign level_o = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r3_full_push_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (level_o == $past(level_o)));

  a_r4_empty_pop_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> (level_o == '0));
endmodule

// File: rtl/spi_mst_engine.sv
module spi_mst_engine
  import spi_mst_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic             cpol_i,
  input  logic             cke_i,
  input  logic             smp_i,
  input  logic [1:0]       ws_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_empty_i,
  input  logic [MAX_W-1:0] tx_data_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [MAX_W-1:0] rx_data_o,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  localparam int BW = $clog2(MAX_W);

  logic             busy_q, half_q;
  logic [BW-1:0]    bit_q;
  logic [DIV_W-1:0] div_q;
  logic [MAX_W-1:0] tx_q, rx_q, rx_next, aligned;
  logic [5:0]       wbits;
  logic             tick, last, word_end, sample, load;

  assign wbits    = size_bits(ws_i);
  assign last     = ({1'b0, bit_q} == (wbits - 6'd1));
  assign tick     = busy_q && (div_q >= div_i);
  assign word_end = tick && half_q && last;
  assign sample   = tick && (half_q == smp_i);
  assign load     = en_i && run_i && !tx_empty_i && (!busy_q || word_end);
  assign rx_next  = {rx_q[MAX_W-2:0], miso_i};
  assign aligned  = tx_data_i << (6'd32 - wbits);

  assign tx_pop_o  = load;
  assign rx_push_o = word_end;
  assign rx_data_o = smp_i ? rx_next : rx_q;
  assign busy_o    = busy_q;
  assign mosi_o    = busy_q ? tx_q[MAX_W-1] : 1'b0;
  // cke set: idle level in first half of a bit; clear: active level first
  assign sclk_o    = busy_q ? (cpol_i ^ (cke_i ? half_q : ~half_q)) : cpol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      bit_q  <= '0;
      div_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      bit_q  <= '0;
      div_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (busy_q) div_q <= tick ? '0 : div_q + 1'b1;
      if (sample) rx_q <= rx_next;
      if (load) begin
        busy_q <= 1'b1;
        half_q <= 1'b0;
        bit_q  <= '0;
        div_q  <= '0;
        tx_q   <= aligned;
        rx_q   <= '0;
      end else if (word_end) begin
        busy_q <= 1'b0;
        half_q <= 1'b0;
        bit_q  <= '0;
      end else if (tick) begin
        if (!half_q) begin
          half_q <= 1'b1;
        end else begin
          half_q <= 1'b0;
          bit_q  <= bit_q + 1'b1;
          tx_q   <= tx_q << 1;
        end
      end
    end
  end

  a_r12_off_stops_shifter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && !rx_push_o));
endmodule

// File: rtl/spi_byte_fifo_master.sv
module spi_byte_fifo_master
  import spi_mst_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  parameter int DIV_W      = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic        clr_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        ss_no
);
  localparam int LW = $clog2(FIFO_BYTES + 1);
  localparam logic [31:0] CTRL_MASK = (32'd1 << C_MST) | (32'd1 << C_CPOL) | (32'd1 << C_CKE) |
                                      (32'd1 << C_SMP) | (32'd3 << C_WS)   | (32'd1 << C_ON)  |
                                      (32'd1 << C_ENH) | (32'd1 << C_ASS);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_BAUD = 2'd3;

  logic [31:0]      ctrl_q;
  logic [DIV_W-1:0] baud_q;
  logic             rov_q;

  logic             on, mst, cpol, cke, smp, enh, auto_ss;
  logic [1:0]       ws;
  logic [LW-1:0]    cap, tx_lvl, rx_lvl;
  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic             rx_push, rx_pop, rx_full, rx_empty;
  logic [31:0]      tx_head, rx_head, rx_word;
  logic             busy;
  logic [31:0]      status;

  assign on      = ctrl_q[C_ON];
  assign mst     = ctrl_q[C_MST];
  assign cpol    = ctrl_q[C_CPOL];
  assign cke     = ctrl_q[C_CKE];
  assign smp     = ctrl_q[C_SMP];
  assign enh     = ctrl_q[C_ENH];
  assign auto_ss = ctrl_q[C_ASS];
  assign ws      = ctrl_q[C_WS +: 2];

  assign cap     = enh ? LW'(FIFO_BYTES >> size_shift(ws)) : LW'(1);
  assign tx_push = wr_i && (addr_i == A_DATA);
  assign rx_pop  = rd_i && (addr_i == A_DATA);

  spi_mst_fifo #(.DW(MAX_W), .DEPTH(FIFO_BYTES)) u_txq (
    .clk_i, .rst_ni, .flush_i(!on), .cap_i(cap),
    .push_i(tx_push), .wdata_i(wdata_i & size_mask(ws)),
    .pop_i(tx_pop), .rdata_o(tx_head), .level_o(tx_lvl),
    .full_o(tx_full), .empty_o(tx_empty)
  );

  spi_mst_fifo #(.DW(MAX_W), .DEPTH(FIFO_BYTES)) u_rxq (
    .clk_i, .rst_ni, .flush_i(!on), .cap_i(cap),
    .push_i(rx_push), .wdata_i(rx_word),
    .pop_i(rx_pop), .rdata_o(rx_head), .level_o(rx_lvl),
    .full_o(rx_full), .empty_o(rx_empty)
  );

  spi_mst_engine #(.DIV_W(DIV_W)) u_eng (
    .clk_i, .rst_ni, .en_i(on), .run_i(mst),
    .cpol_i(cpol), .cke_i(cke), .smp_i(smp), .ws_i(ws), .div_i(baud_q),
    .tx_empty_i(tx_empty), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_word), .busy_o(busy),
    .sclk_o, .mosi_o, .miso_i
  );

  assign ss_no = ~(auto_ss & busy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      baud_q <= '0;
      rov_q  <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i & CTRL_MASK;
      if (wr_i && addr_i == A_BAUD) baud_q <= wdata_i[DIV_W-1:0];
      if (rx_push && rx_full)
        rov_q <= 1'b1;
      else if (clr_i && addr_i == A_STAT && wdata_i[S_ROV])
        rov_q <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[S_ROV] = rov_q;
    status[S_TXL +: LW] = tx_lvl;
    status[S_RXL +: LW] = rx_lvl;
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_STAT:  rdata_o = status;
      A_DATA:  rdata_o = rx_empty ? '0 : rx_head;
      default: rdata_o = 32'(baud_q);
    endcase
  end

  a_r10_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rov_q && !(clr_i && addr_i == A_STAT && wdata_i[S_ROV])) |=> rov_q);

  a_r11_ss_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_no) |-> (!auto_ss || $past(tx_empty || !on || !mst)));
endmodule

// File: tb/sim_spi_byte_fifo_master.sv
module sim_spi_byte_fifo_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, clr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, miso, ss_n;
  logic        clk_fed = 1'b0, cpol_tb = 1'b0;

  int n_chk = 0, n_fail = 0;
  int ss_low = 0, sclk_rise = 0, ss_falls = 0;
  logic sclk_prev = 1'b0, ss_prev = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  // serial input: loopback, or a level derived from SCLK for sample-point tests
  assign miso = clk_fed ? (sclk ^ cpol_tb) : mosi;

  spi_byte_fifo_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .clr_i(clr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .ss_no(ss_n)
  );

  always @(negedge clk) begin
    if (!ss_n) ss_low++;
    if (sclk && !sclk_prev) sclk_rise++;
    if (!ss_n && ss_prev) ss_falls++;
    sclk_prev = sclk;
    ss_prev = ss_n;
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic w1c(input logic [31:0] d);
    @(negedge clk);
    clr = 1'b1; addr = 2'd1; wdata = d;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [31:0] cw(input bit on, input bit mst, input bit cpol, input bit cke,
                                     input bit smp, input logic [1:0] ws, input bit enh, input bit ass);
    return (32'(on) << 15) | (32'(mst) << 5) | (32'(cpol) << 6) | (32'(cke) << 8) |
           (32'(smp) << 9) | (32'(ws) << 10) | (32'(enh) << 16) | (32'(ass) << 28);
  endfunction

  task automatic mon_clear();
    @(negedge clk);
    #1;
    ss_low = 0; sclk_rise = 0; ss_falls = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!ss_n) @(negedge clk);
  endtask

  task automatic flush();
    wreg(2'd0, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rreg(2'd0, d); chk("R1 ctrl reset", d, 32'd0);
    rreg(2'd1, d); chk("R1 status reset", d, 32'd0);
    rreg(2'd3, d); chk("R1 divider reset", d, 32'd0);
    chk("R1 ss reset", 32'(ss_n), 32'd1);
    chk("R1 sclk reset", 32'(sclk), 32'd0);
    wreg(2'd0, 32'hFFFF_FFFF);
    rreg(2'd0, d); chk("R1 ctrl mask", d, 32'h1001_8F60);
    wreg(2'd3, 32'h0000_FFFF);
    rreg(2'd3, d); chk("R1 divider mask", d, 32'h0000_01FF);
    flush();
  endtask

  task automatic t_loop8_b2b();
    logic [31:0] d;
    wreg(2'd3, 32'd1);
    wreg(2'd0, cw(1,1,0,1,0,2'd0,1,1));
    mon_clear();
    wreg(2'd2, 32'hA5); wreg(2'd2, 32'h3C); wreg(2'd2, 32'h81);
    wait_done();
    chk("R6 back-to-back ss window", 32'(ss_low), 32'd96);
    chk("R6 single ss assertion", 32'(ss_falls), 32'd1);
    rreg(2'd1, d); chk("R9 rx level", 32'(d[28:24]), 32'd3);
    chk("R9 tx level drained", 32'(d[20:16]), 32'd0);
    rreg(2'd2, d); chk("R6 word0", d, 32'hA5);
    rreg(2'd2, d); chk("R6 word1", d, 32'h3C);
    rreg(2'd2, d); chk("R6 word2", d, 32'h81);
    flush();
  endtask

  task automatic t_sizes();
    logic [31:0] d;
    wreg(2'd3, 32'd0);
    wreg(2'd0, cw(1,1,0,1,0,2'd1,1,1));
    mon_clear();
    wreg(2'd2, 32'hABCD_BEEF);
    wait_done();
    chk("R5 16-bit window", 32'(ss_low), 32'd32);
    rreg(2'd2, d); chk("R2 16-bit masked word", d, 32'h0000_BEEF);
    wreg(2'd0, cw(1,1,0,1,1,2'd2,1,1));
    mon_clear();
    wreg(2'd2, 32'hDEAD_BEEF);
    wait_done();
    chk("R5 32-bit window", 32'(ss_low), 32'd64);
    rreg(2'd2, d); chk("R6 32-bit word", d, 32'hDEAD_BEEF);
    wreg(2'd3, 32'd1);
    wreg(2'd0, cw(1,1,0,1,0,2'd3,1,1));
    mon_clear();
    wreg(2'd2, 32'h1234);
    wait_done();
    chk("R2 reserved code as 8-bit window", 32'(ss_low), 32'd32);
    rreg(2'd2, d); chk("R2 reserved code data", d, 32'h34);
    flush();
  endtask

  task automatic cap_case(input logic [1:0] ws, input bit enh, input int exp, input string tag);
    logic [31:0] d;
    wreg(2'd0, cw(1,0,0,1,0,ws,enh,1));
    for (int i = 0; i < 20; i++) wreg(2'd2, 32'(i));
    rreg(2'd1, d); chk(tag, 32'(d[20:16]), 32'(exp));
    chk("R12 no shifting without master", 32'(ss_n), 32'd1);
    flush();
  endtask

  task automatic t_capacity();
    cap_case(2'd0, 1'b1, 16, "R3 cap 8-bit");
    cap_case(2'd1, 1'b1, 8,  "R3 cap 16-bit");
    cap_case(2'd2, 1'b1, 4,  "R3 cap 32-bit");
    cap_case(2'd0, 1'b0, 1,  "R3 cap unbuffered");
  endtask

  task automatic t_pop_empty();
    logic [31:0] d;
    wreg(2'd3, 32'd0);
    wreg(2'd0, cw(1,1,0,1,0,2'd0,1,1));
    rreg(2'd2, d); rreg(2'd2, d);
    rreg(2'd1, d); chk("R4 empty pop level", 32'(d[28:24]), 32'd0);
    wreg(2'd2, 32'h5A);
    wait_done();
    rreg(2'd1, d); chk("R4 level after one word", 32'(d[28:24]), 32'd1);
    rreg(2'd2, d); chk("R4 data after empty pops", d, 32'h5A);
    flush();
  endtask

  task automatic t_baud();
    wreg(2'd3, 32'd3);
    wreg(2'd0, cw(1,1,0,1,0,2'd0,1,1));
    mon_clear();
    wreg(2'd2, 32'h96);
    wait_done();
    chk("R5 divider 3 window", 32'(ss_low), 32'd64);
    chk("R5 sclk pulses", 32'(sclk_rise), 32'd8);
    flush();
  endtask

  task automatic t_clock_mode();
    wreg(2'd3, 32'd2);
    wreg(2'd0, cw(1,1,1,0,0,2'd0,1,1));
    @(negedge clk);
    chk("R7 idle high", 32'(sclk), 32'd1);
    wreg(2'd2, 32'h0F);
    @(negedge clk);
    chk("R7 edge clear: active at word start", 32'(sclk), 32'd0);
    wait_done();
    flush();
    wreg(2'd0, cw(1,1,1,1,0,2'd0,1,1));
    wreg(2'd2, 32'h0F);
    @(negedge clk);
    chk("R7 edge set: idle at word start", 32'(sclk), 32'd1);
    wait_done();
    chk("R7 idle high after word", 32'(sclk), 32'd1);
    flush();
  endtask

  task automatic t_sample_point();
    logic [31:0] d;
    wreg(2'd3, 32'd1);
    clk_fed = 1'b1; cpol_tb = 1'b0;
    wreg(2'd0, cw(1,1,0,1,0,2'd0,1,1));
    wreg(2'd2, 32'h00);
    wait_done();
    rreg(2'd2, d); chk("R8 mid-bit sample", d, 32'h00);
    wreg(2'd0, cw(1,1,0,1,1,2'd0,1,1));
    wreg(2'd2, 32'h00);
    wait_done();
    rreg(2'd2, d); chk("R8 end-of-bit sample", d, 32'hFF);
    clk_fed = 1'b0;
    flush();
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    wreg(2'd3, 32'd0);
    wreg(2'd0, cw(1,1,0,1,0,2'd0,1,1));
    for (int i = 1; i <= 17; i++) wreg(2'd2, 32'(i));
    wait_done();
    rreg(2'd1, d);
    chk("R10 overflow flag", 32'(d[6]), 32'd1);
    chk("R9 rx level full", 32'(d[28:24]), 32'd16);
    for (int i = 1; i <= 16; i++) begin
      rreg(2'd2, d); chk("R10 kept word", d, 32'(i));
    end
    rreg(2'd1, d); chk("R10 flag sticky after reads", 32'(d[6]), 32'd1);
    w1c(32'h0000_0040);
    rreg(2'd1, d); chk("R10 flag cleared", 32'(d[6]), 32'd0);
    flush();
  endtask

  task automatic t_manual_ss();
    logic [31:0] d;
    wreg(2'd3, 32'd0);
    wreg(2'd0, cw(1,1,0,1,0,2'd0,1,0));
    mon_clear();
    wreg(2'd2, 32'hC3);
    repeat (40) @(negedge clk);
    chk("R11 ss stays high when auto off", 32'(ss_low), 32'd0);
    rreg(2'd2, d); chk("R11 word still exchanged", d, 32'hC3);
    flush();
  endtask

  task automatic t_module_off();
    logic [31:0] d;
    wreg(2'd3, 32'd7);
    wreg(2'd0, cw(1,1,1,1,0,2'd0,1,1));
    wreg(2'd2, 32'h11); wreg(2'd2, 32'h22);
    repeat (30) @(negedge clk);
    chk("R11 ss low mid-transfer", 32'(ss_n), 32'd0);
    wreg(2'd0, cw(0,1,1,1,0,2'd0,1,1));
    @(negedge clk);
    chk("R12 sclk idle after off", 32'(sclk), 32'd1);
    chk("R12 ss high after off", 32'(ss_n), 32'd1);
    rreg(2'd1, d); chk("R12 fifos emptied", d, 32'd0);
    flush();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_loop8_b2b();
    t_sizes();
    t_capacity();
    t_pop_empty();
    t_baud();
    t_clock_mode();
    t_sample_point();
    t_overflow();
    t_manual_ss();
    t_module_off();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule